// File: doc/BRIEF.md
# I2C Master Status and FIFO Watermark Flags

This block gathers the status, interrupt-enable and FIFO-control state for a FIFO-based I2C master controller. The bus engine feeds it the live fill levels of the transmit and receive FIFOs, one-cycle event pulses (stop detected, NACK detected, arbitration lost) and two live busy levels. From these it builds a status word: level-type data-request flags come from comparing each fill level against a programmable watermark, and event flags are sticky until software writes 1 to them. A single interrupt output combines every status bit with its enable.

A small control state machine tracks the module enable and a software reset. Its states are ST_OFF (core disabled), ST_ON (core enabled) and ST_RST (one cycle of reset). The transitions are: ST_OFF to ST_ON on a control write with the enable bit set; ST_ON to ST_OFF on a control write with the enable bit clear; ST_OFF or ST_ON to ST_RST on a control write with the reset bit set (the reset bit takes priority over the enable bit); ST_RST to ST_OFF unconditionally after one cycle. Control writes can also pulse a flush request to either FIFO. A read-only parameter word reports each FIFO depth as a power-of-two exponent.

Register word addresses: 0 parameter, 1 control, 2 status, 3 interrupt enable, 4 FIFO control, 5 FIFO status; other addresses read zero and ignore writes. Reads are combinational from `addr`; writes take effect on the rising clock edge when `wr_en` is high.

Top module: `i2cs_status_unit`

## Requirements
- R1: After reset the control, interrupt-enable and FIFO-control words read 0, `core_en`, `irq`, `tx_flush` and `rx_flush` are 0, and with both fill levels at 0 the status word reads 0x0000_0001.
- R2: The parameter word (address 0) reads the transmit depth exponent TX_LOG2 in bits 3:0 and the receive depth exponent RX_LOG2 in bits 11:8, all other bits 0 (0x0000_0202 by default).
- R3: Status bit 0 (transmit request) is 1 exactly while `tx_level` is less than or equal to the transmit watermark held in FIFO-control bits [TX_LOG2-1:0].
- R4: Status bit 1 (receive ready) is 1 exactly while `rx_level` is greater than the receive watermark held in FIFO-control bits starting at bit 16.
- R5: A one-cycle pulse on `ev_stop`, `ev_nack` or `ev_arb_lost` sets status bit 9, 10 or 11 respectively from the next cycle, and the bit stays set without further pulses.
- R6: Writing the status word clears each event flag whose bit is written 1 and leaves flags written 0 unchanged; a write of 0x7F00 clears all three; when an event pulse and a clearing write hit the same flag in the same cycle, the flag ends set.
- R7: Status bit 24 follows `mst_busy` and bit 25 follows `bus_busy` in the same cycle; writes to the status word do not change them.
- R8: Interrupt-enable bits 0, 1, 9, 10 and 11 are writable and all others read 0; `irq` is 1 exactly while some status bit and its enable bit are both 1.
- R9: A control write with bit 0 set and bit 1 clear moves to ST_ON, making `core_en` 1 and control bit 0 read 1 from the next cycle; a control write with bit 0 clear and bit 1 clear returns to ST_OFF.
- R10: A control write with bit 1 set clears event flags (even one pulsed in the same cycle), watermarks and enables at that edge, and enters ST_RST for exactly one cycle in which `tx_flush` and `rx_flush` are both 1 and `core_en` is 0, then ST_OFF; any register write applied during ST_RST is ignored.
- R11: A control write with bit 8 set pulses `tx_flush`, and with bit 9 set pulses `rx_flush`, high for exactly the one cycle after the write.
- R12: The FIFO status word (address 5) reads `tx_level` in bits 7:0 and `rx_level` in bits 23:16, other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| tx_level | input | TX_LOG2+1 | Transmit FIFO fill count |
| rx_level | input | RX_LOG2+1 | Receive FIFO fill count |
| ev_stop | input | 1 | Stop-condition pulse from bus engine |
| ev_nack | input | 1 | NACK pulse from bus engine |
| ev_arb_lost | input | 1 | Arbitration-lost pulse from bus engine |
| mst_busy | input | 1 | Live master-busy level |
| bus_busy | input | 1 | Live bus-busy level |
| core_en | output | 1 | Core enable, high in ST_ON |
| tx_flush | output | 1 | Transmit FIFO flush pulse |
| rx_flush | output | 1 | Receive FIFO flush pulse |
| irq | output | 1 | Combined interrupt |

## Verification
An event pulse can land in the same cycle as a write that clears the same flag, either through a write-1 to the status word or through a software reset. The bench drives the pulse and the write onto the same clock edge and then reads the status word: after a write-1 collision the flag must still read 1, while after a software-reset collision it must read 0. A following lone clearing write confirms the flag is then cleared normally.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ON  = 2'd1,
        ST_RST = 2'd2
    } ctl_state_e;

    typedef enum logic [2:0] {
        A_PARAM = 3'd0,
        A_CTRL  = 3'd1,
        A_STAT  = 3'd2,
        A_IEN   = 3'd3,
        A_FCTRL = 3'd4,
        A_FSTAT = 3'd5
    } reg_addr_e;

    localparam int B_TXREQ   = 0;
    localparam int B_RXRDY   = 1;
    localparam int B_MBUSY   = 24;
    localparam int B_BBUSY   = 25;
    localparam int B_CEN     = 0;
    localparam int B_SRST    = 1;
    localparam int B_TXFL    = 8;
    localparam int B_RXFL    = 9;
    localparam int RXWM_LSB  = 16;
    localparam int RXCNT_LSB = 16;

    localparam int NUM_EVT = 3;
    // event order: stop, nack, arbitration lost
    localparam int EVT_BIT [NUM_EVT] = '{9, 10, 11};

    localparam logic [31:0] IEN_MASK = 32'h0000_0E03;

endpackage

// File: rtl/i2cs_wm_cmp.sv
module i2cs_wm_cmp #(
    parameter int  CW    = 3,
    parameter int  WMW   = 2,
    parameter bit  ABOVE = 1'b0
) (
    input  logic [CW-1:0]  level_i,
    input  logic [WMW-1:0] mark_i,
    output logic           flag_o
);
    logic [CW-1:0] mark_x;
    assign mark_x = CW'(mark_i);

    generate
        if (ABOVE) begin : g_above
            assign flag_o = (level_i > mark_x);
        end else begin : g_at_or_below
            assign flag_o = (level_i <= mark_x);
        end
    endgenerate
endmodule

// File: rtl/i2cs_evt_flag.sv
module i2cs_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic w1c_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (clr_i)  flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (w1c_i)  flag_o <= 1'b0;
    end

    // R5: a pulse not overridden by software reset sets the flag
    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_i && !clr_i |=> flag_o);

    // R6: a set flag stays set unless cleared
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o && !w1c_i && !clr_i |=> flag_o);

    // R6: a flag only drops after a clearing request
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(w1c_i || clr_i));
endmodule

// File: rtl/i2cs_ctrl_fsm.sv
module i2cs_ctrl_fsm
    import i2cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic       en_bit,
    input  logic       srst_bit,
    output logic       core_en,
    output logic       srst_active
);
    ctl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (ctrl_we && srst_bit)    state_d = ST_RST;
                else if (ctrl_we && en_bit) state_d = ST_ON;
            end
            ST_ON: begin
                if (ctrl_we && srst_bit)     state_d = ST_RST;
                else if (ctrl_we && !en_bit) state_d = ST_OFF;
            end
            ST_RST:  state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        core_en     = 1'b0;
        srst_active = 1'b0;
        unique case (state_q)
            ST_ON:   core_en     = 1'b1;
            ST_RST:  srst_active = 1'b1;
            default: ;
        endcase
    end

    // R10: reset state lasts one cycle and returns to ST_OFF
    p_rst_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RST |=> state_q == ST_OFF);

    // R10: a reset write always enters ST_RST
    p_rst_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && srst_bit |=> srst_active);

    // R9: the core turns on only after an enabling control write
    p_core_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_en) |-> $past(ctrl_we && en_bit && !srst_bit));
endmodule

// File: rtl/i2cs_status_unit.sv
module i2cs_status_unit
    import i2cs_pkg::*;
#(
    parameter int TX_LOG2 = 2,
    parameter int RX_LOG2 = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         addr,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_data,
    input  logic [TX_LOG2:0]   tx_level,
    input  logic [RX_LOG2:0]   rx_level,
    input  logic               ev_stop,
    input  logic               ev_nack,
    input  logic               ev_arb_lost,
    input  logic               mst_busy,
    input  logic               bus_busy,
    output logic               core_en,
    output logic               tx_flush,
    output logic               rx_flush,
    output logic               irq
);
    localparam int TX_CW  = TX_LOG2 + 1;
    localparam int RX_CW  = RX_LOG2 + 1;
    localparam int TX_WMW = TX_LOG2;
    localparam int RX_WMW = RX_LOG2;

    logic               srst_active;
    logic               wr_ok, ctrl_we, sw_clr;
    logic [31:0]        ien_q;
    logic [TX_WMW-1:0]  tx_wm_q;
    logic [RX_WMW-1:0]  rx_wm_q;
    logic               tx_fl_q, rx_fl_q;
    logic               tx_req, rx_rdy;
    logic [NUM_EVT-1:0] ev_in, ev_flag;
    logic [31:0]        status_w;

    assign wr_ok   = wr_en && !srst_active;
    assign ctrl_we = wr_ok && (addr == A_CTRL);
    assign sw_clr  = ctrl_we && wr_data[B_SRST];

    i2cs_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .en_bit      (wr_data[B_CEN]),
        .srst_bit    (wr_data[B_SRST]),
        .core_en     (core_en),
        .srst_active (srst_active)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q   <= '0;
            tx_wm_q <= '0;
            rx_wm_q <= '0;
        end else if (sw_clr) begin
            ien_q   <= '0;
            tx_wm_q <= '0;
            rx_wm_q <= '0;
        end else if (wr_ok) begin
            if (addr == A_IEN) ien_q <= wr_data & IEN_MASK;
            if (addr == A_FCTRL) begin
                tx_wm_q <= wr_data[TX_WMW-1:0];
                rx_wm_q <= wr_data[RXWM_LSB +: RX_WMW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_fl_q <= 1'b0;
            rx_fl_q <= 1'b0;
        end else begin
            tx_fl_q <= ctrl_we && wr_data[B_TXFL];
            rx_fl_q <= ctrl_we && wr_data[B_RXFL];
        end
    end

    assign tx_flush = tx_fl_q || srst_active;
    assign rx_flush = rx_fl_q || srst_active;

    i2cs_wm_cmp #(.CW(TX_CW), .WMW(TX_WMW), .ABOVE(1'b0)) u_tx_cmp (
        .level_i (tx_level),
        .mark_i  (tx_wm_q),
        .flag_o  (tx_req)
    );

    i2cs_wm_cmp #(.CW(RX_CW), .WMW(RX_WMW), .ABOVE(1'b1)) u_rx_cmp (
        .level_i (rx_level),
        .mark_i  (rx_wm_q),
        .flag_o  (rx_rdy)
    );

    assign ev_in = {ev_arb_lost, ev_nack, ev_stop};

    generate
        for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_evt
            i2cs_evt_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (ev_in[gi]),
                .w1c_i  (wr_ok && (addr == A_STAT) && wr_data[EVT_BIT[gi]]),
                .clr_i  (sw_clr),
                .flag_o (ev_flag[gi])
            );
        end
    endgenerate

    always_comb begin
        status_w          = '0;
        status_w[B_TXREQ] = tx_req;
        status_w[B_RXRDY] = rx_rdy;
        for (int i = 0; i < NUM_EVT; i++) status_w[EVT_BIT[i]] = ev_flag[i];
        status_w[B_MBUSY] = mst_busy;
        status_w[B_BBUSY] = bus_busy;
    end

    assign irq = |(status_w & ien_q);

    always_comb begin
        rd_data = '0;
        case (addr)
            A_PARAM: begin
                rd_data[3:0]  = 4'(TX_LOG2);
                rd_data[11:8] = 4'(RX_LOG2);
            end
            A_CTRL:  rd_data[B_CEN] = core_en;
            A_STAT:  rd_data = status_w;
            A_IEN:   rd_data = ien_q;
            A_FCTRL: begin
                rd_data[TX_WMW-1:0]          = tx_wm_q;
                rd_data[RXWM_LSB +: RX_WMW]  = rx_wm_q;
            end
            A_FSTAT: begin
                rd_data[7:0]                 = 8'(tx_level);
                rd_data[RXCNT_LSB +: 8]      = 8'(rx_level);
            end
            default: rd_data = '0;
        endcase
    end

    // R11: a transmit flush pulse has a flushing write or reset behind it
    p_txflush_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |-> (srst_active || $past(ctrl_we && wr_data[B_TXFL])));

    // R10: writes during the reset cycle leave the enables untouched
    p_rst_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        srst_active |=> ien_q == '0);

    // R8: the interrupt needs an enabled status bit
    p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien_q != '0));
endmodule

// File: tb/i2cs_status_unit_tb.sv
module i2cs_status_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  tx_level = '0;
    logic [2:0]  rx_level = '0;
    logic        ev_stop = 1'b0, ev_nack = 1'b0, ev_arb_lost = 1'b0;
    logic        mst_busy = 1'b0, bus_busy = 1'b0;
    logic        core_en, tx_flush, rx_flush, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cs_status_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .tx_level(tx_level), .rx_level(rx_level),
        .ev_stop(ev_stop), .ev_nack(ev_nack), .ev_arb_lost(ev_arb_lost),
        .mst_busy(mst_busy), .bus_busy(bus_busy), .core_en(core_en),
        .tx_flush(tx_flush), .rx_flush(rx_flush), .irq(irq)
    );

    // {tx_level[3], rx_level[3], tx_wm[2], rx_wm[2], expected {rx_rdy, tx_req}[2]}
    localparam logic [11:0] VEC [8] = '{
        {3'd0, 3'd0, 2'd0, 2'd0, 2'b01},
        {3'd1, 3'd1, 2'd0, 2'd0, 2'b10},
        {3'd2, 3'd2, 2'd2, 2'd2, 2'b01},
        {3'd3, 3'd3, 2'd2, 2'd2, 2'b10},
        {3'd4, 3'd4, 2'd3, 2'd3, 2'b10},
        {3'd3, 3'd0, 2'd3, 2'd3, 2'b01},
        {3'd1, 3'd2, 2'd1, 2'd1, 2'b11},
        {3'd4, 3'd0, 2'd0, 2'd0, 2'b00}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // caller stands at a falling edge; returns at the next falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd1, r); chk("R1 ctrl", r, 32'h0);
        rd(3'd3, r); chk("R1 ien", r, 32'h0);
        rd(3'd4, r); chk("R1 fctrl", r, 32'h0);
        rd(3'd2, r); chk("R1 status", r, 32'h1);
        chk("R1 outputs", {28'h0, core_en, irq, tx_flush, rx_flush}, 32'h0);

        // R2 parameter word
        rd(3'd0, r); chk("R2 param", r, 32'h0000_0202);

        // R3 R4 R12 watermark vector table
        for (int i = 0; i < 8; i++) begin
            tx_level = VEC[i][11:9];
            rx_level = VEC[i][8:6];
            wr(3'd4, {14'h0, VEC[i][3:2], 14'h0, VEC[i][5:4]});
            rd(3'd2, r); chk("R3/R4 status flags", {30'h0, r[1:0]}, {30'h0, VEC[i][1:0]});
            rd(3'd5, r); chk("R12 fifo status", r, {8'h0, 5'h0, VEC[i][8:6], 8'h0, 5'h0, VEC[i][11:9]});
        end
        tx_level = 3'd4; rx_level = 3'd0;
        wr(3'd4, 32'h0);
        rd(3'd2, r); chk("R3 tx above mark", r, 32'h0);

        // R5 sticky events
        ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0;
        ev_nack = 1'b1; @(negedge clk); ev_nack = 1'b0;
        ev_arb_lost = 1'b1; @(negedge clk); ev_arb_lost = 1'b0;
        repeat (2) @(negedge clk);
        rd(3'd2, r); chk("R5 sticky flags", r, 32'h0000_0E00);

        // R6 write-1 clears selectively, write 0 no effect
        wr(3'd2, 32'h0000_0000);
        rd(3'd2, r); chk("R6 zero write", r, 32'h0000_0E00);
        wr(3'd2, 32'h0000_0400);
        rd(3'd2, r); chk("R6 clear nack only", r, 32'h0000_0A00);
        wr(3'd2, 32'h0000_7F00);
        rd(3'd2, r); chk("R6 bulk clear", r, 32'h0);

        // R6 collision: pulse and clear on same edge, set wins
        ev_stop = 1'b1;
        wr(3'd2, 32'h0000_0200);
        ev_stop = 1'b0;
        rd(3'd2, r); chk("R6 set beats clear", r, 32'h0000_0200);
        wr(3'd2, 32'h0000_0200);
        rd(3'd2, r); chk("R6 clear after collision", r, 32'h0);

        // R7 busy levels live and not writable
        mst_busy = 1'b1; bus_busy = 1'b0;
        rd(3'd2, r); chk("R7 master busy", r, 32'h0100_0000);
        wr(3'd2, 32'h0300_0000);
        mst_busy = 1'b0; bus_busy = 1'b1;
        rd(3'd2, r); chk("R7 bus busy", r, 32'h0200_0000);
        bus_busy = 1'b0;

        // R8 interrupt enable and combined interrupt
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, r); chk("R8 enable mask", r, 32'h0000_0E03);
        wr(3'd3, 32'h0000_0200);
        chk("R8 irq idle", {31'h0, irq}, 32'h0);
        ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0;
        chk("R8 irq on stop", {31'h0, irq}, 32'h1);
        wr(3'd2, 32'h0000_0200);
        chk("R8 irq after clear", {31'h0, irq}, 32'h0);
        tx_level = 3'd0;
        wr(3'd3, 32'h0000_0001);
        chk("R8 irq on tx request", {31'h0, irq}, 32'h1);
        wr(3'd3, 32'h0);

        // R9 enable / disable
        wr(3'd1, 32'h1);
        chk("R9 core_en on", {31'h0, core_en}, 32'h1);
        rd(3'd1, r); chk("R9 ctrl readback", r, 32'h1);
        wr(3'd1, 32'h0);
        chk("R9 core_en off", {31'h0, core_en}, 32'h0);

        // R11 flush pulses
        wr(3'd1, 32'h0000_0100);
        chk("R11 tx flush pulse", {30'h0, tx_flush, rx_flush}, 32'h2);
        @(negedge clk);
        chk("R11 tx flush ends", {30'h0, tx_flush, rx_flush}, 32'h0);
        wr(3'd1, 32'h0000_0200);
        chk("R11 rx flush pulse", {30'h0, tx_flush, rx_flush}, 32'h1);
        @(negedge clk);
        chk("R11 rx flush ends", {30'h0, tx_flush, rx_flush}, 32'h0);

        // R10 software reset with collision and ignored write
        wr(3'd1, 32'h1);
        wr(3'd3, 32'h0000_0E03);
        wr(3'd4, 32'h0003_0003);
        ev_nack = 1'b1; @(negedge clk); ev_nack = 1'b0;
        ev_arb_lost = 1'b1;
        wr(3'd1, 32'h0000_0003);
        ev_arb_lost = 1'b0;
        chk("R10 reset cycle outputs", {29'h0, core_en, tx_flush, rx_flush}, 32'h3);
        wr(3'd3, 32'hFFFF_FFFF);
        chk("R10 back to off", {29'h0, core_en, tx_flush, rx_flush}, 32'h0);
        rd(3'd3, r); chk("R10 write ignored in reset", r, 32'h0);
        rd(3'd4, r); chk("R10 watermarks cleared", r, 32'h0);
        tx_level = 3'd1;
        rd(3'd2, r); chk("R10 flags cleared", r, 32'h0);
        rd(3'd1, r); chk("R10 ctrl reads off", r, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule